// File: doc/BRIEF.md
# Byte-Store Read-Merge-Write Adapter

This block connects a processor that issues both byte and 16-bit word accesses to a memory port that moves only whole 16-bit words. Word reads and word writes become a single word transfer each. A byte read becomes one word read, and the wanted byte is handed back to the processor. A byte write becomes two transfers: the containing word is fetched, the new byte is merged into its lane, and the whole word is written back.

Byte lanes follow big-endian order. The even byte address of a word holds its most significant byte. The byte address space is 64 KiB, which is 32 Ki words, so the memory port carries a 15-bit word address.

The processor raises a request and holds it until the adapter pulses its ready output for one cycle. The memory port uses a request/ready pair. The memory may stretch any transfer with wait cycles, and the adapter keeps everything it drives steady while it waits.

Top module: `bsw_adapter`

## Requirements
- R1: While reset is active, and after it is released until a request arrives, `cpu_rdy` and `mem_req` are 0.
- R2: A word write (`cpu_we`=1, `cpu_byte`=0) produces exactly one memory write. `mem_addr` is `cpu_addr[15:1]`, and `mem_wdata` equals `cpu_wdata` unchanged.
- R3: A word read (`cpu_we`=0, `cpu_byte`=0) produces exactly one memory read. `cpu_rdata` equals the `mem_rdata` returned.
- R4: A byte read (`cpu_we`=0, `cpu_byte`=1) produces exactly one memory read. The selected byte is returned on `cpu_rdata[15:8]`, and `cpu_rdata[7:0]` is 0.
- R5: A byte write (`cpu_we`=1, `cpu_byte`=1) produces a memory read and then a memory write, both to `cpu_addr[15:1]`. The byte to store is taken from `cpu_wdata[15:8]`, and the other byte of the written word equals the word that was read.
- R6: Lane selection is big-endian for byte reads and byte writes. `cpu_addr[0]`=0 selects word bits [15:8], and `cpu_addr[0]`=1 selects word bits [7:0].
- R7: The memory may insert any number of wait cycles. While `mem_req`=1 and `mem_rdy`=0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` keep their values into the next cycle.
- R8: The first memory request appears in the cycle after the request is accepted. `cpu_rdy` is 1 for exactly one cycle: the cycle after the final memory handshake, which for a byte write is the write-back. `mem_req` is 0 in that cycle.
- R9: The request fields are captured when the request is accepted. Changes on `cpu_we`, `cpu_byte`, `cpu_addr` or `cpu_wdata` after acceptance have no effect on the transfers or on the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 16 | Write data; a byte store uses bits [15:8] |
| cpu_rdata | output | 16 | Read data, valid while `cpu_rdy` is 1 |
| cpu_rdy | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Word written to memory |
| mem_rdata | input | 16 | Word read from memory, valid with `mem_rdy` |
| mem_rdy | input | 1 | Memory completes the transfer in this cycle |

## Verification
A request present at a clock edge is accepted on that edge. The first memory request is then visible in the next cycle. Each transfer moves on at the edge where `mem_rdy` is high, so the byte-store write-back appears the cycle after its read handshake. `cpu_rdy`, together with the read data, appears the cycle after the final handshake and drops again one cycle later.

The bench drives inputs and compares outputs only at the falling edge. Its reference model walks a list of expected memory transfers one cycle at a time, and its randomly stretched wait counts move that list forward. Every cycle it compares `mem_req`, `cpu_rdy` and the transfer fields against the model. It also scrambles the processor inputs after acceptance, to show those changes have no effect.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_MRG_RD,
    ST_MRG_WR,
    ST_DONE
  } bsw_state_e;

endpackage

// File: rtl/bsw_rst_sync.sv
module bsw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bsw_lane_unit.sv
// Big-endian byte lanes: lane 0 is the most significant byte of the word.
module bsw_lane_unit #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [DATA_W-1:0] merged_o
);

  logic [LANES-1:0][BYTE_W-1:0] lane_v;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HI = DATA_W - 1 - l * BYTE_W;
    assign lane_v[l] = word_i[HI -: BYTE_W];
    assign merged_o[HI -: BYTE_W] = (sel_i == SEL_W'(l)) ? byte_i : lane_v[l];
  end

  assign byte_o = lane_v[sel_i];

endmodule

// File: rtl/bsw_ctrl.sv
module bsw_ctrl
  import bsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_we,
  input  logic cpu_byte,
  input  logic we_q,
  input  logic mem_rdy,
  output logic accept,
  output logic mem_req,
  output logic mem_we,
  output logic merge_load,
  output logic rdata_load,
  output logic done
);

  bsw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          state_d = (cpu_byte && cpu_we) ? ST_MRG_RD : ST_XFER;
        end
      end
      ST_XFER:   if (mem_rdy) state_d = ST_DONE;
      ST_MRG_RD: if (mem_rdy) state_d = ST_MRG_WR;
      ST_MRG_WR: if (mem_rdy) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign accept     = (state_q == ST_IDLE) && cpu_req;
  assign mem_req    = (state_q == ST_XFER) || (state_q == ST_MRG_RD) || (state_q == ST_MRG_WR);
  assign mem_we     = ((state_q == ST_XFER) && we_q) || (state_q == ST_MRG_WR);
  assign merge_load = (state_q == ST_MRG_RD) && mem_rdy;
  assign rdata_load = (state_q == ST_XFER) && !we_q && mem_rdy;
  assign done       = (state_q == ST_DONE);

  // R8
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_rdy && state_q == ST_MRG_RD) |=> (mem_req && mem_we));

endmodule

// File: rtl/bsw_adapter.sv
module bsw_adapter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES   = DATA_W / BYTE_W,
  localparam int SEL_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WADDR_W = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_byte,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy
);

  logic srst_n;
  logic accept, merge_load, rdata_load, done;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d;
  logic              byte_q, byte_d;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [BYTE_W-1:0] lane_byte;
  logic [DATA_W-1:0] merged_word;

  bsw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  bsw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_byte   (cpu_byte),
    .we_q       (we_q),
    .mem_rdy    (mem_rdy),
    .accept     (accept),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .merge_load (merge_load),
    .rdata_load (rdata_load),
    .done       (done)
  );

  bsw_lane_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
    .word_i   (mem_rdata),
    .sel_i    (addr_q[SEL_W-1:0]),
    .byte_i   (wbuf_q[DATA_W-1 -: BYTE_W]),
    .byte_o   (lane_byte),
    .merged_o (merged_word)
  );

  always_comb begin
    addr_d  = addr_q;
    we_d    = we_q;
    byte_d  = byte_q;
    wbuf_d  = wbuf_q;
    rdata_d = rdata_q;
    if (accept) begin
      addr_d = cpu_addr;
      we_d   = cpu_we;
      byte_d = cpu_byte;
      wbuf_d = cpu_wdata;
    end
    if (merge_load) begin
      wbuf_d = merged_word;
    end
    if (rdata_load) begin
      rdata_d = byte_q ? {lane_byte, {(DATA_W-BYTE_W){1'b0}}} : mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      byte_q  <= 1'b0;
      wbuf_q  <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      we_q    <= we_d;
      byte_q  <= byte_d;
      wbuf_q  <= wbuf_d;
      rdata_q <= rdata_d;
    end
  end

  assign mem_addr  = addr_q[ADDR_W-1:SEL_W];
  assign mem_wdata = wbuf_q;
  assign cpu_rdata = rdata_q;
  assign cpu_rdy   = done;

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R8
  rdy_after_xfer_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cpu_rdy) |-> ($past(mem_req) && $past(mem_rdy)));

  // R4
  byte_rd_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rdata_load && byte_q) |=> (cpu_rdata[DATA_W-BYTE_W-1:0] == '0));

endmodule

// File: tb/bsw_adapter_bench.sv
module bsw_adapter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_byte;
  logic [15:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_rdy;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_rdy;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] mem_model [logic [14:0]];

  always #5 clk = ~clk;

  bsw_adapter u_bsw_adapter (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_byte  (cpu_byte),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_rdy   (cpu_rdy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy)
  );

  function automatic logic [15:0] mem_rd(input logic [14:0] wa);
    if (mem_model.exists(wa)) return mem_model[wa];
    return {wa[7:0] ^ 8'h5A, wa[14:7]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge with the adapter idle.
  task automatic do_txn(input bit we, input bit bt, input logic [15:0] a,
                        input logic [15:0] wd, input int long_wait);
    logic [14:0] wa;
    logic [15:0] cur;
    logic [15:0] exp_rd;
    bit          op_we [2];
    logic [15:0] op_dat [2];
    int          n_ops;
    string       tag;
    wa  = a[15:1];
    cur = mem_rd(wa);
    if (!we && !bt)      tag = "R3 word read";
    else if (!we)        tag = "R4 R6 byte read";
    else if (!bt)        tag = "R2 word write";
    else                 tag = "R5 R6 byte write";
    if (we && bt) begin
      n_ops = 2;
      op_we[0] = 1'b0; op_dat[0] = 16'h0;
      op_we[1] = 1'b1;
      op_dat[1] = a[0] ? {cur[15:8], wd[15:8]} : {wd[15:8], cur[7:0]};
    end else begin
      n_ops = 1;
      op_we[0] = we; op_dat[0] = wd;
      op_we[1] = 1'b0; op_dat[1] = 16'h0;
    end
    exp_rd = bt ? {(a[0] ? cur[7:0] : cur[15:8]), 8'h00} : cur;

    chk("R8 idle mem_req", {31'b0, mem_req}, 32'd0);
    chk("R8 idle cpu_rdy", {31'b0, cpu_rdy}, 32'd0);
    cpu_req = 1'b1; cpu_we = we; cpu_byte = bt; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    for (int k = 0; k < n_ops; k++) begin
      int waits;
      waits = (long_wait > 0) ? long_wait : int'($urandom_range(0, 3));
      for (int w = 0; w <= waits; w++) begin
        chk({tag, " R7 mem_req"}, {31'b0, mem_req}, 32'd1);
        chk({tag, " mem_we"}, {31'b0, mem_we}, {31'b0, op_we[k]});
        chk({tag, " mem_addr"}, {17'b0, mem_addr}, {17'b0, wa});
        if (op_we[k]) chk({tag, " mem_wdata"}, {16'b0, mem_wdata}, {16'b0, op_dat[k]});
        // R9: scramble the processor fields after acceptance
        cpu_we = $urandom_range(0, 1); cpu_byte = $urandom_range(0, 1);
        cpu_addr = 16'($urandom); cpu_wdata = 16'($urandom);
        mem_rdy   = (w == waits);
        mem_rdata = (w == waits && !op_we[k]) ? cur : 16'hDEAD;
        if (w == waits && op_we[k]) mem_model[wa] = op_dat[k];
        @(negedge clk);
      end
    end
    mem_rdy = 1'b0; mem_rdata = 16'h0;
    chk("R8 cpu_rdy after last handshake", {31'b0, cpu_rdy}, 32'd1);
    chk("R8 mem_req low at done", {31'b0, mem_req}, 32'd0);
    if (!we) chk({tag, " R9 cpu_rdata"}, {16'b0, cpu_rdata}, {16'b0, exp_rd});
    cpu_req = 1'b0;
    @(negedge clk);
    chk("R8 cpu_rdy single cycle", {31'b0, cpu_rdy}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_byte = 1'b0;
    cpu_addr = 16'h0; cpu_wdata = 16'h0;
    mem_rdata = 16'h0; mem_rdy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset cpu_rdy", {31'b0, cpu_rdy}, 32'd0);
    chk("R1 reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 post-reset mem_req", {31'b0, mem_req}, 32'd0);
      chk("R1 post-reset cpu_rdy", {31'b0, cpu_rdy}, 32'd0);
    end

    do_txn(1'b1, 1'b0, 16'h1234, 16'hBEEF, 0);   // R2
    do_txn(1'b0, 1'b0, 16'h1234, 16'h0000, 0);   // R3 read back
    do_txn(1'b1, 1'b1, 16'h1234, 16'hA7FF, 0);   // R5 R6 even lane
    do_txn(1'b0, 1'b0, 16'h1234, 16'h0000, 0);
    do_txn(1'b1, 1'b1, 16'h1235, 16'h3C00, 0);   // R5 R6 odd lane
    do_txn(1'b0, 1'b1, 16'h1234, 16'h0000, 0);   // R4 even
    do_txn(1'b0, 1'b1, 16'h1235, 16'h0000, 0);   // R4 odd
    do_txn(1'b1, 1'b1, 16'hFFFF, 16'h9100, 9);   // R7 long waits, top word
    do_txn(1'b0, 1'b0, 16'hFFFE, 16'h0000, 7);
    do_txn(1'b1, 1'b0, 16'h0000, 16'h0001, 5);
    do_txn(1'b1, 1'b1, 16'h0000, 16'hEE00, 0);
    do_txn(1'b0, 1'b0, 16'h0001, 16'h0000, 0);

    for (int i = 0; i < 200; i++) begin
      logic [15:0] ra;
      ra = {11'h0, 5'($urandom)};
      do_txn($urandom_range(0, 1), $urandom_range(0, 1), ra, 16'($urandom), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule